// File: doc/BRIEF.md
# Synthesizer Counter Programming Front End

This block holds the divider settings of an integer-N frequency synthesizer and hands them to the counter chain. A 20-bit setting word packs a 9-bit main divide value, a 4-bit swallow value, a 6-bit reference divide value and a prescaler-enable flag. The word can be loaded in one of three ways, chosen by two mode pins. In the shift mode it enters one bit at a time on a slow serial clock. In the byte mode it is written in three pieces from an 8-bit bus, each piece with its own strobe. In the pin mode the counter values come straight from dedicated inputs.

Loaded words land in a working register and can be copied into a standby register by a copy strobe. A select input then switches the counters between the two registers with no reload, so the synthesizer can hop between two channels. A separate 8-bit option register carries control flags: power-down, continuous counter load, two routings for the test data output, and a disable for the divider monitor outputs. The flags act only while an active-low option-enable pin is held low. In shift mode the option register is double buffered, so its outputs change only when its write strobe falls.

Every strobe, the serial clock and the data inputs are slow asynchronous signals. Each passes through a two-flop synchronizer, and its edges are then found on the system clock.

Top module: `synth_prog_if`

## Requirements
- R1: Mode decode: `mode_direct`=1 selects pin mode. `mode_direct`=0 with `mode_serial`=1 selects shift mode. Both low select byte mode.
- R2: In shift mode, with `ser_load` and `enh_wr` both low, each rising `ser_clk` shifts `ser_data` into the working word, first bit in ending at bit 19. Word layout from bit 19 down to bit 0: R[5:4], M[8:7], prescaler enable, M[6:0], R[3:0], A[3:0].
- R3: A rising `hop_wr` (shift or byte mode), or a rising `ser_load` in shift mode, copies the working word into the standby word. The standby word changes at no other time.
- R4: Outside pin mode, the outputs show the working word when `freq_sel`=1 and the standby word when `freq_sel`=0.
- R5: In byte mode, a rising `wr_hi` loads `par_data[3:0]` into word bits 19:16. A rising `wr_mid` loads `par_data` into bits 15:8. A rising `wr_lo` loads `par_data` into bits 7:0.
- R6: In pin mode, M[8:7] and R[5:4] read zero, and M[6:0], A, R[3:0] and the prescaler enable follow the direct pins, whatever `freq_sel` is.
- R7: In shift mode, while `enh_wr` is high, each rising `ser_clk` shifts `ser_data` into the option shift register and not into the working word. The option outputs change only on the falling edge of `enh_wr`.
- R8: In byte mode, a rising `enh_wr` loads `par_data` into the option register.
- R9: With `enh_n`=0, option bit 3 drives `pwr_down`, bit 4 drives `cnt_load`, bit 5 drives `dout_msel`, bit 6 drives `dout_pre` and bit 7 drives `mon_dis`. Bits 2:0 have no effect. With `enh_n`=1, all five flag outputs are 0.
- R10: Reset clears the working word, the standby word and the option register to zero.
- R11: A strobe or serial clock that belongs to a mode other than the current one leaves both words unchanged.
- R12: While `ser_load` is high, `ser_clk` edges do not shift the working word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_direct | input | 1 | Pin mode select |
| mode_serial | input | 1 | Shift mode select when not in pin mode |
| freq_sel | input | 1 | 1 = working word, 0 = standby word |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, first bit is most significant |
| ser_load | input | 1 | Serial load: blocks shifting while high, copies on rise |
| enh_wr | input | 1 | Option register write strobe |
| hop_wr | input | 1 | Copy working word to standby word on rise |
| par_data | input | 8 | Byte-mode data bus |
| wr_hi | input | 1 | Byte strobe for word bits 19:16 |
| wr_mid | input | 1 | Byte strobe for word bits 15:8 |
| wr_lo | input | 1 | Byte strobe for word bits 7:0 |
| enh_n | input | 1 | Active-low enable for the option flags |
| dir_m | input | 7 | Pin-mode M[6:0] |
| dir_a | input | 4 | Pin-mode A[3:0] |
| dir_r | input | 4 | Pin-mode R[3:0] |
| dir_pre | input | 1 | Pin-mode prescaler enable |
| m_val | output | 9 | Selected main divide value |
| a_val | output | 4 | Selected swallow value |
| r_val | output | 6 | Selected reference divide value |
| pre_en | output | 1 | Selected prescaler enable flag |
| pwr_down | output | 1 | Power-down flag |
| cnt_load | output | 1 | Continuous counter load flag |
| dout_msel | output | 1 | Route modulus select to data out |
| dout_pre | output | 1 | Route raw prescaler output to data out |
| mon_dis | output | 1 | Disable divider monitor outputs |

## Verification
Some properties are checked on every cycle. The standby word holds except on a copy event and then takes the previous working word. Every serial shift moves the working word up one place. A high `ser_load` blocks shifting. Pin mode freezes the working word and forces the high counter bits to zero. The option register moves only on a capture event. The option flags stay low while `enh_n` is high. The directed scenarios cover the rest: the bit order of a full 20-bit shift, the byte-to-field mapping, hopping between two stored words, the option flag map with the reserved bits set, the buffered option update on the strobe fall, and strobes that arrive in the wrong mode.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  // Setting word geometry
  parameter int WORD_W  = 20;
  parameter int BUS_W   = 8;
  parameter int M_W     = 9;
  parameter int A_W     = 4;
  parameter int R_W     = 6;
  parameter int M_LO_W  = 7;
  parameter int R_LO_W  = 4;

  // Field positions inside the setting word (serial order depends on these)
  parameter int POS_A    = 0;
  parameter int POS_RLO  = POS_A + A_W;
  parameter int POS_MLO  = POS_RLO + R_LO_W;
  parameter int POS_PRE  = POS_MLO + M_LO_W;
  parameter int POS_MHI  = POS_PRE + 1;
  parameter int POS_RHI  = POS_MHI + (M_W - M_LO_W);
  parameter int HI_W     = WORD_W - POS_MHI;

  // Option register geometry
  parameter int ENH_W    = 8;
  parameter int ENH_RSV  = 3;
  parameter int ENH_ACT  = ENH_W - ENH_RSV;

  // Absolute option bit positions
  parameter int OPT_PWDN = 3;
  parameter int OPT_CLD  = 4;
  parameter int OPT_MSEL = 5;
  parameter int OPT_PRE  = 6;
  parameter int OPT_MOFF = 7;

  typedef enum logic [1:0] {
    IFM_BYTE  = 2'd0,
    IFM_SHIFT = 2'd1,
    IFM_PIN   = 2'd2
  } ifm_e;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/prog_word_reg.sv
module prog_word_reg
  import synth_prog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  input  logic              ld_hi,
  input  logic              ld_mid,
  input  logic              ld_lo,
  input  logic [BUS_W-1:0]  pdata,
  input  logic              copy,
  output logic [WORD_W-1:0] pri,
  output logic [WORD_W-1:0] sec
);
  logic [WORD_W-1:0] pri_nx;
  logic [WORD_W-1:0] sec_nx;
  logic              pri_en;
  logic              sec_en;

  always_comb begin
    pri_nx = pri;
    if (shift_en) pri_nx = {pri[WORD_W-2:0], shift_bit};
    if (ld_hi)    pri_nx[WORD_W-1:POS_MHI]  = pdata[HI_W-1:0];
    if (ld_mid)   pri_nx[POS_MHI-1:POS_MLO] = pdata;
    if (ld_lo)    pri_nx[POS_MLO-1:0]       = pdata;
  end

  assign pri_en = shift_en | ld_hi | ld_mid | ld_lo;
  assign sec_en = copy;
  assign sec_nx = pri;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri <= '0;
    end else if (pri_en) begin
      pri <= pri_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec <= '0;
    end else if (sec_en) begin
      sec <= sec_nx;
    end
  end
endmodule

// File: rtl/enh_reg.sv
module enh_reg
  import synth_prog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               shift_bit,
  input  logic               cap_ser,
  input  logic               cap_par,
  input  logic [ENH_ACT-1:0] pdata_act,
  output logic [ENH_ACT-1:0] act
);
  logic [ENH_W-1:0]   sh;
  logic [ENH_W-1:0]   sh_nx;
  logic [ENH_ACT-1:0] act_nx;
  logic               act_en;

  always_comb begin
    sh_nx  = {sh[ENH_W-2:0], shift_bit};
    act_nx = cap_par ? pdata_act : sh[ENH_W-1:ENH_RSV];
    act_en = cap_ser | cap_par;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
    end else if (shift_en) begin
      sh <= sh_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= '0;
    end else if (act_en) begin
      act <= act_nx;
    end
  end
endmodule

// File: rtl/field_select.sv
module field_select
  import synth_prog_pkg::*;
(
  input  logic               pin_mode,
  input  logic               freq_sel,
  input  logic [WORD_W-1:0]  pri,
  input  logic [WORD_W-1:0]  sec,
  input  logic [M_LO_W-1:0]  dir_m,
  input  logic [A_W-1:0]     dir_a,
  input  logic [R_LO_W-1:0]  dir_r,
  input  logic               dir_pre,
  input  logic               enh_n,
  input  logic [ENH_ACT-1:0] opt,
  output logic [M_W-1:0]     m_val,
  output logic [A_W-1:0]     a_val,
  output logic [R_W-1:0]     r_val,
  output logic               pre_en,
  output logic               pwr_down,
  output logic               cnt_load,
  output logic               dout_msel,
  output logic               dout_pre,
  output logic               mon_dis
);
  logic [WORD_W-1:0]  word;
  logic [WORD_W-1:0]  pin_word;
  logic [ENH_ACT-1:0] opt_live;

  always_comb begin
    pin_word                         = '0;
    pin_word[POS_PRE]                = dir_pre;
    pin_word[POS_PRE-1:POS_MLO]      = dir_m;
    pin_word[POS_MLO-1:POS_RLO]      = dir_r;
    pin_word[POS_RLO-1:POS_A]        = dir_a;
  end

  always_comb begin
    if (pin_mode)      word = pin_word;
    else if (freq_sel) word = pri;
    else               word = sec;
  end

  assign m_val  = {word[POS_RHI-1:POS_MHI], word[POS_PRE-1:POS_MLO]};
  assign r_val  = {word[WORD_W-1:POS_RHI], word[POS_MLO-1:POS_RLO]};
  assign a_val  = word[POS_RLO-1:POS_A];
  assign pre_en = word[POS_PRE];

  assign opt_live  = enh_n ? '0 : opt;
  assign pwr_down  = opt_live[OPT_PWDN - ENH_RSV];
  assign cnt_load  = opt_live[OPT_CLD  - ENH_RSV];
  assign dout_msel = opt_live[OPT_MSEL - ENH_RSV];
  assign dout_pre  = opt_live[OPT_PRE  - ENH_RSV];
  assign mon_dis   = opt_live[OPT_MOFF - ENH_RSV];
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_direct,
  input  logic              mode_serial,
  input  logic              freq_sel,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_load,
  input  logic              enh_wr,
  input  logic              hop_wr,
  input  logic [BUS_W-1:0]  par_data,
  input  logic              wr_hi,
  input  logic              wr_mid,
  input  logic              wr_lo,
  input  logic              enh_n,
  input  logic [M_LO_W-1:0] dir_m,
  input  logic [A_W-1:0]    dir_a,
  input  logic [R_LO_W-1:0] dir_r,
  input  logic              dir_pre,
  output logic [M_W-1:0]    m_val,
  output logic [A_W-1:0]    a_val,
  output logic [R_W-1:0]    r_val,
  output logic              pre_en,
  output logic              pwr_down,
  output logic              cnt_load,
  output logic              dout_msel,
  output logic              dout_pre,
  output logic              mon_dis
);
  localparam int S_SCLK = 0;
  localparam int S_LOAD = 1;
  localparam int S_EWR  = 2;
  localparam int S_HOP  = 3;
  localparam int S_WHI  = 4;
  localparam int S_WMID = 5;
  localparam int S_WLO  = 6;
  localparam int NSTB   = 7;
  localparam int DAT_W  = BUS_W + 1;

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  // Synchronizers
  logic [NSTB-1:0]  stb_raw;
  logic [NSTB-1:0]  stb_q;
  logic [NSTB-1:0]  stb_d;
  logic [NSTB-1:0]  rise;
  logic [DAT_W-1:0] dat_q;

  assign stb_raw = {wr_lo, wr_mid, wr_hi, hop_wr, enh_wr, ser_load, ser_clk};

  sync_chain #(.W(NSTB), .STAGES(SYNC_STAGES)) u_stb_sync (
    .clk(clk), .rst_n(rst_s_n), .d(stb_raw), .q(stb_q)
  );

  sync_chain #(.W(DAT_W), .STAGES(SYNC_STAGES)) u_dat_sync (
    .clk(clk), .rst_n(rst_s_n), .d({par_data, ser_data}), .q(dat_q)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) stb_d <= '0;
    else          stb_d <= stb_q;
  end

  assign rise = stb_q & ~stb_d;

  // Mode decode
  ifm_e mode;
  logic is_pin, is_shift, is_byte;

  always_comb begin
    if (mode_direct)      mode = IFM_PIN;
    else if (mode_serial) mode = IFM_SHIFT;
    else                  mode = IFM_BYTE;
  end

  assign is_pin   = (mode == IFM_PIN);
  assign is_shift = (mode == IFM_SHIFT);
  assign is_byte  = (mode == IFM_BYTE);

  // Event decode
  logic             sdat;
  logic [BUS_W-1:0] pdat;
  logic             ser_shift, enh_shift, copy_evt;
  logic             ld_hi, ld_mid, ld_lo;
  logic             enh_cap_ser, enh_cap_par, enh_evt;

  assign sdat = dat_q[0];
  assign pdat = dat_q[DAT_W-1:1];

  assign ser_shift   = is_shift & rise[S_SCLK] & ~stb_q[S_LOAD] & ~stb_q[S_EWR];
  assign enh_shift   = is_shift & rise[S_SCLK] & ~stb_q[S_LOAD] &  stb_q[S_EWR];
  assign copy_evt    = ~is_pin & (rise[S_HOP] | (is_shift & rise[S_LOAD]));
  assign ld_hi       = is_byte & rise[S_WHI];
  assign ld_mid      = is_byte & rise[S_WMID];
  assign ld_lo       = is_byte & rise[S_WLO];
  assign enh_cap_ser = is_shift & stb_d[S_EWR] & ~stb_q[S_EWR];
  assign enh_cap_par = is_byte & rise[S_EWR];
  assign enh_evt     = enh_cap_ser | enh_cap_par;

  // Storage
  logic [WORD_W-1:0]  pri_word;
  logic [WORD_W-1:0]  sec_word;
  logic [ENH_ACT-1:0] enh_act;

  prog_word_reg u_word (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .shift_en (ser_shift),
    .shift_bit(sdat),
    .ld_hi    (ld_hi),
    .ld_mid   (ld_mid),
    .ld_lo    (ld_lo),
    .pdata    (pdat),
    .copy     (copy_evt),
    .pri      (pri_word),
    .sec      (sec_word)
  );

  enh_reg u_enh (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .shift_en (enh_shift),
    .shift_bit(sdat),
    .cap_ser  (enh_cap_ser),
    .cap_par  (enh_cap_par),
    .pdata_act(pdat[BUS_W-1:ENH_RSV]),
    .act      (enh_act)
  );

  field_select u_sel (
    .pin_mode (is_pin),
    .freq_sel (freq_sel),
    .pri      (pri_word),
    .sec      (sec_word),
    .dir_m    (dir_m),
    .dir_a    (dir_a),
    .dir_r    (dir_r),
    .dir_pre  (dir_pre),
    .enh_n    (enh_n),
    .opt      (enh_act),
    .m_val    (m_val),
    .a_val    (a_val),
    .r_val    (r_val),
    .pre_en   (pre_en),
    .pwr_down (pwr_down),
    .cnt_load (cnt_load),
    .dout_msel(dout_msel),
    .dout_pre (dout_pre),
    .mon_dis  (mon_dis)
  );
endmodule

// File: rtl/synth_prog_if_chk.sv
module synth_prog_if_chk
  import synth_prog_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               mode_direct,
  input logic               enh_n,
  input logic               load_lvl,
  input logic               ser_shift,
  input logic               copy_evt,
  input logic               enh_evt,
  input logic [WORD_W-1:0]  pri,
  input logic [WORD_W-1:0]  sec,
  input logic [ENH_ACT-1:0] enh_act,
  input logic [M_W-1:0]     m_val,
  input logic [R_W-1:0]     r_val,
  input logic               pwr_down,
  input logic               cnt_load,
  input logic               dout_msel,
  input logic               dout_pre,
  input logic               mon_dis
);
  AST_PIN_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mode_direct |-> (m_val[M_W-1:M_LO_W] == '0 && r_val[R_W-1:R_LO_W] == '0)); // R6

  AST_OPT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    enh_n |-> !(pwr_down | cnt_load | dout_msel | dout_pre | mon_dis)); // R9

  AST_SEC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_evt |=> $stable(sec)); // R3

  AST_SEC_TAKES_PRI: assert property (@(posedge clk) disable iff (!rst_n)
    copy_evt |=> (sec == $past(pri))); // R3

  AST_SHIFT_MOVES_UP: assert property (@(posedge clk) disable iff (!rst_n)
    ser_shift |=> (pri[WORD_W-1:1] == $past(pri[WORD_W-2:0]))); // R2

  AST_LOAD_BLOCKS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    load_lvl |-> !ser_shift); // R12

  AST_PIN_FREEZES_PRI: assert property (@(posedge clk) disable iff (!rst_n)
    mode_direct |=> $stable(pri)); // R11

  AST_OPT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_evt |=> $stable(enh_act)); // R7
endmodule

bind synth_prog_if synth_prog_if_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_s_n),
  .mode_direct(mode_direct),
  .enh_n      (enh_n),
  .load_lvl   (stb_q[S_LOAD]),
  .ser_shift  (ser_shift),
  .copy_evt   (copy_evt),
  .enh_evt    (enh_evt),
  .pri        (pri_word),
  .sec        (sec_word),
  .enh_act    (enh_act),
  .m_val      (m_val),
  .r_val      (r_val),
  .pwr_down   (pwr_down),
  .cnt_load   (cnt_load),
  .dout_msel  (dout_msel),
  .dout_pre   (dout_pre),
  .mon_dis    (mon_dis)
);

// File: tb/sim_synth_prog_if.sv
module sim_synth_prog_if;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_direct = 0, mode_serial = 0, freq_sel = 0;
  logic       ser_clk = 0, ser_data = 0, ser_load = 0, enh_wr = 0, hop_wr = 0;
  logic [7:0] par_data = '0;
  logic       wr_hi = 0, wr_mid = 0, wr_lo = 0, enh_n = 1;
  logic [6:0] dir_m = '0;
  logic [3:0] dir_a = '0, dir_r = '0;
  logic       dir_pre = 0;
  logic [8:0] m_val;
  logic [3:0] a_val;
  logic [5:0] r_val;
  logic       pre_en, pwr_down, cnt_load, dout_msel, dout_pre, mon_dis;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  synth_prog_if u0 (
    .clk(clk), .rst_n(rst_n), .mode_direct(mode_direct), .mode_serial(mode_serial),
    .freq_sel(freq_sel), .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .enh_wr(enh_wr), .hop_wr(hop_wr), .par_data(par_data), .wr_hi(wr_hi),
    .wr_mid(wr_mid), .wr_lo(wr_lo), .enh_n(enh_n), .dir_m(dir_m), .dir_a(dir_a),
    .dir_r(dir_r), .dir_pre(dir_pre), .m_val(m_val), .a_val(a_val), .r_val(r_val),
    .pre_en(pre_en), .pwr_down(pwr_down), .cnt_load(cnt_load), .dout_msel(dout_msel),
    .dout_pre(dout_pre), .mon_dis(mon_dis)
  );

  // Word as seen at the ports, in the R2 layout
  function automatic logic [19:0] obs_word();
    return {r_val[5:4], m_val[8:7], pre_en, m_val[6:0], r_val[3:0], a_val};
  endfunction

  function automatic logic [4:0] obs_opt();
    return {mon_dis, dout_pre, dout_msel, cnt_load, pwr_down};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_word(input string tag, input logic fs, input logic [19:0] exp);
    freq_sel = fs;
    tick(1);
    check(tag, {12'h0, obs_word()}, {12'h0, exp});
  endtask

  task automatic sclk_bit(input logic b);
    ser_data = b;
    tick(4);
    ser_clk = 1'b1;
    tick(4);
    ser_clk = 1'b0;
  endtask

  task automatic shift_n(input logic [19:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sclk_bit(v[i]);
    tick(4);
  endtask

  // 0:wr_hi 1:wr_mid 2:wr_lo 3:hop_wr 4:ser_load 5:enh_wr
  task automatic pulse(input int which);
    case (which)
      0: wr_hi = 1'b1;
      1: wr_mid = 1'b1;
      2: wr_lo = 1'b1;
      3: hop_wr = 1'b1;
      4: ser_load = 1'b1;
      default: enh_wr = 1'b1;
    endcase
    tick(4);
    wr_hi = 0; wr_mid = 0; wr_lo = 0; hop_wr = 0; ser_load = 0; enh_wr = 0;
    tick(5);
  endtask

  task automatic t_reset();
    mode_serial = 1;
    chk_word("R10 working word after reset", 1'b1, 20'h0);
    chk_word("R10 standby word after reset", 1'b0, 20'h0);
    enh_n = 0;
    tick(1);
    check("R10 option flags after reset", {27'h0, obs_opt()}, 32'h0);
  endtask

  task automatic t_serial();
    mode_serial = 1;
    shift_n(20'hB6D2E, 20);
    chk_word("R2 serial word in working register", 1'b1, 20'hB6D2E);
    chk_word("R4 standby untouched before load", 1'b0, 20'h0);
    pulse(4);
    chk_word("R3 ser_load rise copies to standby", 1'b0, 20'hB6D2E);
    shift_n(20'h4A935, 20);
    chk_word("R4 select low keeps standby", 1'b0, 20'hB6D2E);
    chk_word("R4 select high shows new working word", 1'b1, 20'h4A935);
  endtask

  task automatic t_load_block();
    ser_load = 1;
    tick(4);
    shift_n(20'h7, 3);
    ser_load = 0;
    tick(5);
    chk_word("R12 no shift while ser_load high", 1'b1, 20'h4A935);
    chk_word("R3 standby after second load", 1'b0, 20'h4A935);
  endtask

  task automatic t_parallel();
    mode_serial = 0;
    par_data = 8'hF9; pulse(0);
    par_data = 8'h5A; pulse(1);
    par_data = 8'hC3; pulse(2);
    chk_word("R5 byte writes to field map", 1'b1, 20'h95AC3);
    chk_word("R1 byte mode standby not yet copied", 1'b0, 20'h4A935);
    pulse(3);
    chk_word("R3 hop_wr copies to standby", 1'b0, 20'h95AC3);
  endtask

  task automatic t_ignore();
    mode_serial = 0;
    shift_n(20'hFFFFF, 20);
    chk_word("R11 serial clocks ignored in byte mode", 1'b1, 20'h95AC3);
    mode_serial = 1;
    par_data = 8'h00; pulse(1);
    chk_word("R11 byte strobe ignored in shift mode", 1'b1, 20'h95AC3);
  endtask

  task automatic t_enh_serial();
    mode_serial = 1;
    enh_n = 0;
    enh_wr = 1;
    tick(4);
    shift_n(20'hF8, 8);
    tick(1);
    check("R7 option outputs hold until strobe falls", {27'h0, obs_opt()}, 32'h0);
    chk_word("R7 option shift leaves working word", 1'b1, 20'h95AC3);
    enh_wr = 0;
    tick(5);
    check("R9 all five flags set", {27'h0, obs_opt()}, 32'h1F);
    enh_n = 1;
    tick(1);
    check("R9 flags masked by enh_n high", {27'h0, obs_opt()}, 32'h0);
    enh_n = 0;
    enh_wr = 1;
    tick(4);
    shift_n(20'h57, 8);
    enh_wr = 0;
    tick(5);
    check("R9 flag map with reserved bits set", {27'h0, obs_opt()}, 32'h0A);
  endtask

  task automatic t_enh_par();
    mode_serial = 0;
    par_data = 8'h28;
    pulse(5);
    check("R8 byte-mode option write", {27'h0, obs_opt()}, 32'h05);
  endtask

  task automatic t_direct();
    mode_direct = 1;
    dir_m = 7'h55; dir_a = 4'h9; dir_r = 4'h6; dir_pre = 1;
    chk_word("R6 pin mode with select high", 1'b1, 20'h0D569);
    chk_word("R1 pin mode with select low", 1'b0, 20'h0D569);
    par_data = 8'h11; pulse(1);
    pulse(3);
    mode_direct = 0;
    mode_serial = 0;
    chk_word("R11 working word untouched by pin-mode strobes", 1'b1, 20'h95AC3);
    chk_word("R11 standby untouched by pin-mode hop", 1'b0, 20'h95AC3);
  endtask

  initial begin
    rst_n = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_serial();
    t_load_block();
    t_parallel();
    t_ignore();
    t_enh_serial();
    t_enh_par();
    t_direct();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule